// File: doc/BRIEF.md
# Single-Wire Consumer-Control Bus Frame Transmitter

This block sends one frame at a time onto an open-drain, single-wire consumer-control bus (CEC). Software places one word at a time into a single-entry holding register. Each word carries one data byte and four flags: first byte of the frame, last byte of the frame, broadcast, and retry. The block waits for the bus to stay idle for the required time. It then drives the start bit and one ten-bit block per byte: eight data bits sent most significant first, an end-of-message bit, and an acknowledge slot. It judges the acknowledge slot, checks for lost arbitration while the initiator address is on the line, and watches for a bus anomaly.

All timing counts advance on a strobe `tick`, nominally one pulse every 32 µs. The block only pulls the line low through `drive_low`. It reads the actual wire level through `line_in`, which passes through a synchronizer first. Each frame ends with exactly one single-cycle outcome pulse. A negatively acknowledged frame raises the completion pulse and the NAK pulse together.

Top module: `cec_tx`

## Requirements
- R1: A word enters the holding register when `wr_en` is high. The byte is `wr_data`, and the flags are `wr_start`, `wr_eom`, `wr_bcast` and `wr_retry`. A frame begins only from a word whose `wr_start` is 1. A word with `wr_start` 0 found while the block is idle is discarded, and the line is not driven.
- R2: Before the start bit, the line must be sampled high for a required number of ticks, where one bit period is 75 ticks. The count is 3 bit periods if the first word has `wr_retry` set. Otherwise it is 7 bit periods if the previous frame on the bus was this block's own completed frame, and 5 bit periods if not. Any low sample restarts the count.
- R3: The start bit holds the line low for 116 ticks and lasts 141 ticks in total.
- R4: Each byte goes out as data bits 7 down to 0, then the end-of-message bit (equal to the `wr_eom` flag), then the acknowledge slot, which is sent as a 1. A 0 bit is low for 47 ticks and a 1 bit is low for 19 ticks. Every bit lasts 75 ticks.
- R5: The acknowledge slot is sampled 33 ticks into the bit. For a directed frame (`wr_bcast` 0), a low sample is an acknowledge and a high sample is a NAK. For a broadcast frame, a low sample is a NAK. A NAK ends the frame at the end of that block with `ev_done` and `ev_nak` high in the same cycle.
- R6: After an acknowledged block whose end-of-message bit is 1, `ev_done` pulses without `ev_nak`. Otherwise the next byte is taken from the holding register. At most one of `ev_done`, `ev_underrun`, `ev_arb_lost` and `ev_anomaly` is high in any cycle.
- R7: If the holding register is empty at the end of a non-final acknowledged block, `ev_underrun` pulses, the frame is abandoned, and `ev_done` stays low.
- R8: During the first four data bits of the first byte, a 1 bit that reads low 27 ticks into the bit (the 19-tick low time plus the 8-tick transition allowance) means arbitration is lost. `ev_arb_lost` pulses, and the line is released and not driven again for that frame.
- R9: Any other released bit outside the acknowledge slot that reads low at that same point is a bus anomaly. The block pulls the line low for 113 ticks, then pulses `ev_anomaly` and goes idle.
- R10: `tx_empty` is 1 exactly when the holding register holds no word. A word becomes visible one clock after `wr_en`, and the register empties when the word is taken.
- R11: When `en` is 0, the state machine returns to idle, `drive_low` is 0 from the next clock on, and the holding register is emptied.
- R12: After reset, `drive_low` is 0, `tx_empty` is 1 and every event output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; 0 aborts and releases the line |
| tick | input | 1 | Timing strobe, one pulse per bus tick |
| wr_en | input | 1 | Write a word into the holding register |
| wr_data | input | 8 | Data byte of the word |
| wr_start | input | 1 | Word is the first byte of a frame |
| wr_eom | input | 1 | Word is the last byte of a frame |
| wr_bcast | input | 1 | Frame is broadcast |
| wr_retry | input | 1 | Frame is a retry (short idle wait) |
| line_in | input | 1 | Sensed bus level (1 = released/high) |
| drive_low | output | 1 | 1 pulls the bus low |
| tx_empty | output | 1 | Holding register is empty |
| ev_done | output | 1 | Frame finished (pulse) |
| ev_nak | output | 1 | Block was not acknowledged (pulse, with ev_done) |
| ev_underrun | output | 1 | Next byte missing mid-frame (pulse) |
| ev_arb_lost | output | 1 | Arbitration lost (pulse) |
| ev_anomaly | output | 1 | Bus anomaly handled (pulse) |

## Verification
The bench rebuilds bytes from the widths of the low pulses on the wire. A design that swaps the 0 and 1 low times, sends the least significant bit first, or gets the end-of-message bit wrong therefore shows up as wrong bytes. The acknowledge slot is driven both ways for directed and broadcast frames. An inverted broadcast rule would report NAK on a clean broadcast, and a NAK that did not stop the frame would let a second byte onto the wire. The bench measures the idle gap for a first frame, a following frame and a retry, so any mix-up among the three counts stands out. It also forces a low level once inside the address bits and once outside them, to catch a design that confuses lost arbitration with an anomaly, keeps driving after losing, or gets the error pulse length wrong. Further directed cases cover a missing second byte, a word without the start flag, and removal of enable during the start bit.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef struct packed {
    logic       start;
    logic       eom;
    logic       bcast;
    logic       retry;
    logic [7:0] data;
  } tx_word_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_START,
    S_BIT,
    S_ERR
  } tx_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cec_tx_sync.sv
module cec_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r[0] <= 1'b1;
        else     r[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) r[i] <= 1'b1;
        else     r[i] <= r[i-1];
      end
    end
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/cec_tx_hold.sv
module cec_tx_hold
  import cec_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     wr,
  input  tx_word_t wdata,
  input  logic     pop,
  output logic     valid,
  output tx_word_t q
);
  always_ff @(posedge clk) begin
    if (rst || clr) valid <= 1'b0;
    else if (wr)    valid <= 1'b1;
    else if (pop)   valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr) q <= wdata;
  end

  // R6: a word is only taken when one is present
  p_pop_needs_word_r6: assert property (@(posedge clk) disable iff (rst)
    pop |-> valid);
endmodule

// File: rtl/cec_tx.sv
module cec_tx
  import cec_tx_pkg::*;
#(
  parameter int START_LO    = 116,
  parameter int START_TOT   = 141,
  parameter int BIT_LO0     = 47,
  parameter int BIT_LO1     = 19,
  parameter int BIT_TOT     = 75,
  parameter int ACK_SAMPLE  = 33,
  parameter int XITION      = 8,
  parameter int ERR_LO      = 113,
  parameter int IDLE_NEW    = 5,
  parameter int IDLE_NEXT   = 7,
  parameter int IDLE_RETRY  = 3,
  parameter int ADDR_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_start,
  input  logic       wr_eom,
  input  logic       wr_bcast,
  input  logic       wr_retry,
  input  logic       line_in,
  output logic       drive_low,
  output logic       tx_empty,
  output logic       ev_done,
  output logic       ev_nak,
  output logic       ev_underrun,
  output logic       ev_arb_lost,
  output logic       ev_anomaly
);
  localparam int MAXC = imax(imax(IDLE_NEXT * BIT_TOT, IDLE_NEW * BIT_TOT),
                             imax(imax(IDLE_RETRY * BIT_TOT, START_TOT), ERR_LO));
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] K_START_LO  = CW'(START_LO);
  localparam logic [CW-1:0] K_START_END = CW'(START_TOT - 1);
  localparam logic [CW-1:0] K_LO0       = CW'(BIT_LO0);
  localparam logic [CW-1:0] K_LO1       = CW'(BIT_LO1);
  localparam logic [CW-1:0] K_BIT_END   = CW'(BIT_TOT - 1);
  localparam logic [CW-1:0] K_ACK       = CW'(ACK_SAMPLE);
  localparam logic [CW-1:0] K_CHK       = CW'(BIT_LO1 + XITION);
  localparam logic [CW-1:0] K_ERR_END   = CW'(ERR_LO - 1);
  localparam logic [CW-1:0] K_NEED_NEW  = CW'(IDLE_NEW * BIT_TOT - 1);
  localparam logic [CW-1:0] K_NEED_NEXT = CW'(IDLE_NEXT * BIT_TOT - 1);
  localparam logic [CW-1:0] K_NEED_RTY  = CW'(IDLE_RETRY * BIT_TOT - 1);
  localparam logic [3:0]    LASTB       = 4'd9;
  localparam logic [3:0]    K_ADDR      = 4'(ADDR_BITS);

  logic     line_s;
  logic     hold_valid, pop;
  tx_word_t hold_q, w_in;

  always_comb begin
    w_in.start = wr_start;
    w_in.eom   = wr_eom;
    w_in.bcast = wr_bcast;
    w_in.retry = wr_retry;
    w_in.data  = wr_data;
  end

  cec_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(line_s)
  );

  cec_tx_hold u_hold (
    .clk(clk), .rst(rst), .clr(!en), .wr(wr_en), .wdata(w_in),
    .pop(pop), .valid(hold_valid), .q(hold_q)
  );

  tx_state_t     state, state_n;
  logic [CW-1:0] cnt, cnt_n, need_q, need_n;
  logic [3:0]    bit_idx, bit_n;
  logic [9:0]    sh, sh_n;
  logic          first_q, first_n, bc_q, bc_n, nak_q, nak_n, sent_q, sent_n;
  logic          e_done, e_nak, e_und, e_arb, e_anom, drv_n, cur_bit, nxt_bit;

  assign cur_bit = sh[LASTB - bit_idx];
  assign nxt_bit = sh_n[LASTB - bit_n];

  always_comb begin
    state_n = state;  cnt_n = cnt;   need_n = need_q; bit_n = bit_idx;
    sh_n = sh;        first_n = first_q; bc_n = bc_q;
    nak_n = nak_q;    sent_n = sent_q;   pop = 1'b0;
    e_done = 1'b0; e_nak = 1'b0; e_und = 1'b0; e_arb = 1'b0; e_anom = 1'b0;
    if (!en) begin
      state_n = S_IDLE;
      cnt_n   = '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (!line_s) sent_n = 1'b0;
          if (hold_valid) begin
            pop = 1'b1;
            if (hold_q.start) begin
              sh_n    = {hold_q.data, hold_q.eom, 1'b1};
              bc_n    = hold_q.bcast;
              first_n = 1'b1;
              cnt_n   = '0;
              state_n = S_WAIT;
              need_n  = hold_q.retry ? K_NEED_RTY : (sent_q ? K_NEED_NEXT : K_NEED_NEW);
            end
          end
        end
        S_WAIT: begin
          if (!line_s) begin
            cnt_n  = '0;
            sent_n = 1'b0;
          end else if (tick) begin
            if (cnt == need_q) begin
              state_n = S_START;
              cnt_n   = '0;
            end else cnt_n = cnt + 1'b1;
          end
        end
        S_START: if (tick) begin
          if (cnt == K_START_END) begin
            state_n = S_BIT;
            cnt_n   = '0;
            bit_n   = '0;
          end else cnt_n = cnt + 1'b1;
        end
        S_BIT: if (tick) begin
          if (cur_bit && bit_idx != LASTB && cnt == K_CHK && !line_s) begin
            cnt_n = '0;
            if (first_q && bit_idx < K_ADDR) begin
              state_n = S_IDLE;
              e_arb   = 1'b1;
            end else state_n = S_ERR;
          end else if (cnt == K_BIT_END) begin
            cnt_n = '0;
            if (bit_idx == LASTB) begin
              if (nak_q) begin
                e_done = 1'b1; e_nak = 1'b1; sent_n = 1'b1; state_n = S_IDLE;
              end else if (sh[1]) begin
                e_done = 1'b1; sent_n = 1'b1; state_n = S_IDLE;
              end else if (hold_valid) begin
                pop     = 1'b1;
                sh_n    = {hold_q.data, hold_q.eom, 1'b1};
                first_n = 1'b0;
                bit_n   = '0;
              end else begin
                e_und   = 1'b1;
                state_n = S_IDLE;
              end
            end else bit_n = bit_idx + 1'b1;
          end else begin
            if (bit_idx == LASTB && cnt == K_ACK) nak_n = bc_q ? !line_s : line_s;
            cnt_n = cnt + 1'b1;
          end
        end
        S_ERR: if (tick) begin
          if (cnt == K_ERR_END) begin
            state_n = S_IDLE;
            cnt_n   = '0;
            e_anom  = 1'b1;
          end else cnt_n = cnt + 1'b1;
        end
        default: state_n = S_IDLE;
      endcase
    end
    drv_n = en && ((state_n == S_START && cnt_n < K_START_LO) ||
                   (state_n == S_BIT && cnt_n < (nxt_bit ? K_LO1 : K_LO0)) ||
                   (state_n == S_ERR));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; cnt <= '0; need_q <= '0; bit_idx <= '0; sh <= '0;
      first_q <= 1'b0; bc_q <= 1'b0; nak_q <= 1'b0; sent_q <= 1'b0;
      drive_low <= 1'b0; ev_done <= 1'b0; ev_nak <= 1'b0;
      ev_underrun <= 1'b0; ev_arb_lost <= 1'b0; ev_anomaly <= 1'b0;
    end else begin
      state <= state_n; cnt <= cnt_n; need_q <= need_n; bit_idx <= bit_n; sh <= sh_n;
      first_q <= first_n; bc_q <= bc_n; nak_q <= nak_n; sent_q <= sent_n;
      drive_low <= drv_n; ev_done <= e_done; ev_nak <= e_nak;
      ev_underrun <= e_und; ev_arb_lost <= e_arb; ev_anomaly <= e_anom;
    end
  end

  assign tx_empty = !hold_valid;

  // R11: disable releases the line by the next clock
  p_release_off_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> !drive_low);
  // R5: a NAK is always reported together with completion
  p_nak_with_done_r5: assert property (@(posedge clk) disable iff (rst)
    ev_nak |-> ev_done);
  // R6: one outcome per cycle
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_done, ev_underrun, ev_arb_lost, ev_anomaly}));
  // R8: lost arbitration leaves the line released
  p_arb_release_r8: assert property (@(posedge clk) disable iff (rst)
    ev_arb_lost |=> !drive_low);
  // R7: underrun only when no word was waiting
  p_underrun_empty_r7: assert property (@(posedge clk) disable iff (rst)
    ev_underrun |-> $past(!hold_valid));
  // R9: anomaly is reported at the end of the error low pulse
  p_anom_after_low_r9: assert property (@(posedge clk) disable iff (rst)
    ev_anomaly |-> $past(drive_low));
endmodule

// File: tb/cec_tx_tb.sv
`timescale 1ns/1ps
module cec_tx_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_start = 1'b0, wr_eom = 1'b0, wr_bcast = 1'b0, wr_retry = 1'b0;
  logic line_in, drive_low, tx_empty;
  logic ev_done, ev_nak, ev_underrun, ev_arb_lost, ev_anomaly;
  int   pull = 0;

  assign line_in = !(drive_low || pull > 0);

  cec_tx u_dut (
    .clk(clk), .rst(rst), .en(en), .tick(1'b1),
    .wr_en(wr_en), .wr_data(wr_data), .wr_start(wr_start), .wr_eom(wr_eom),
    .wr_bcast(wr_bcast), .wr_retry(wr_retry), .line_in(line_in),
    .drive_low(drive_low), .tx_empty(tx_empty), .ev_done(ev_done), .ev_nak(ev_nak),
    .ev_underrun(ev_underrun), .ev_arb_lost(ev_arb_lost), .ev_anomaly(ev_anomaly)
  );

  int checks = 0, errors = 0;
  int cyc = 0, fall_n = 0, lowrun = 0, nbits = 0, nrx = 0, arb_fall = 0, t_wr = 0;
  int tfall [0:63];
  int wid   [0:63];
  logic [7:0] rxb [0:3];
  logic       rxe [0:3];
  logic [9:0] acc = '0;
  logic prev = 1'b0, ack_mode = 1'b0;
  logic f_done = 0, f_nak = 0, f_und = 0, f_arb = 0, f_anom = 0;

  // wire monitor and follower model
  always @(negedge clk) begin
    cyc++;
    if (pull > 0) pull--;
    if (ev_done) f_done = 1;
    if (ev_nak) f_nak = 1;
    if (ev_underrun) f_und = 1;
    if (ev_arb_lost) f_arb = 1;
    if (ev_anomaly) f_anom = 1;
    if (drive_low && !prev) begin
      if (fall_n < 64) tfall[fall_n] = cyc;
      fall_n++;
      lowrun = 1;
      if (ack_mode && fall_n > 1 && (fall_n - 1) % 10 == 0) pull = 45;
      if (arb_fall == fall_n) pull = 60;
    end else if (drive_low) begin
      lowrun++;
    end else if (prev) begin
      if (fall_n - 1 < 64) wid[fall_n-1] = lowrun;
      if (lowrun > 90) nbits = 0;
      else begin
        acc = {acc[8:0], (lowrun < 33)};
        nbits++;
        if (nbits == 10) begin
          if (nrx < 4) begin rxb[nrx] = acc[9:2]; rxe[nrx] = acc[1]; end
          nrx++;
          nbits = 0;
        end
      end
    end
    prev = drive_low;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic clr_mon();
    fall_n = 0; nrx = 0; nbits = 0; pull = 0;
    f_done = 0; f_nak = 0; f_und = 0; f_arb = 0; f_anom = 0;
  endtask

  task automatic wr_word(input logic [7:0] d, input logic st, input logic eo,
                         input logic bc, input logic rt);
    @(posedge clk); #2;
    wr_en = 1; wr_data = d; wr_start = st; wr_eom = eo; wr_bcast = bc; wr_retry = rt;
    t_wr = cyc;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 5000; i++) begin
      if (tx_empty) break;
      step(1);
    end
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      if (f_done || f_und || f_arb || f_anom) break;
      step(1);
    end
    step(5);
  endtask

  task automatic send(input int nb, input logic [7:0] b0, input logic [7:0] b1,
                      input logic bc, input logic rt);
    clr_mon();
    wr_word(b0, 1'b1, nb == 1, bc, rt);
    if (nb == 2) begin
      wait_empty();
      wr_word(b1, 1'b0, 1'b1, bc, 1'b0);
    end
    wait_end();
  endtask

  typedef struct packed {
    logic [1:0] nb;
    logic [7:0] b0;
    logic [7:0] b1;
    logic       bc;
    logic       ack;
    logic       nak;
    logic [1:0] rx;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{2'd1, 8'h40, 8'h00, 1'b0, 1'b1, 1'b0, 2'd1},
    '{2'd2, 8'h04, 8'h8F, 1'b0, 1'b1, 1'b0, 2'd2},
    '{2'd2, 8'h05, 8'h36, 1'b0, 1'b0, 1'b1, 2'd1},
    '{2'd2, 8'h0F, 8'h36, 1'b1, 1'b0, 1'b0, 2'd2},
    '{2'd1, 8'h0F, 8'h00, 1'b1, 1'b1, 1'b1, 2'd1}
  };

  task automatic do_reset();
    rst = 1; en = 0;
    step(5);
    rst = 0;
    step(1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int gap;
    do_reset();
    // R12 reset state
    chk(drive_low == 0, "R12 drive_low", drive_low, 0);
    chk(tx_empty == 1, "R12 tx_empty", tx_empty, 1);
    chk({ev_done, ev_nak, ev_underrun, ev_arb_lost, ev_anomaly} == 0, "R12 events",
        {ev_done, ev_nak, ev_underrun, ev_arb_lost, ev_anomaly}, 0);
    en = 1;
    step(2);

    // table of frames: R4 bytes, R5 acknowledge rule, R6 completion
    for (int v = 0; v < 5; v++) begin
      ack_mode = VEC[v].ack;
      arb_fall = 0;
      send(int'(VEC[v].nb), VEC[v].b0, VEC[v].b1, VEC[v].bc, 1'b0);
      chk(f_done == 1, "R6 done", f_done, 1);
      chk(f_nak == VEC[v].nak, "R5 nak", f_nak, VEC[v].nak);
      chk(nrx == int'(VEC[v].rx), "R5 bytes sent", nrx, VEC[v].rx);
      chk(rxb[0] == VEC[v].b0, "R4 byte0", rxb[0], VEC[v].b0);
      chk(rxe[0] == (VEC[v].nb == 2'd1), "R4 eom0", rxe[0], VEC[v].nb == 2'd1);
      if (VEC[v].rx == 2'd2) begin
        chk(rxb[1] == VEC[v].b1, "R4 byte1", rxb[1], VEC[v].b1);
        chk(rxe[1] == 1'b1, "R4 eom1", rxe[1], 1);
      end
      step(10);
    end

    // R2 / R3 / R4 / R10 timing after a fresh reset
    do_reset();
    en = 1; ack_mode = 1; arb_fall = 0;
    clr_mon();
    wr_word(8'h40, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(tx_empty == 0, "R10 word held", tx_empty, 0);
    step(2);
    chk(tx_empty == 1, "R10 word taken", tx_empty, 1);
    wait_end();
    gap = tfall[0] - t_wr;
    chk(gap >= 375 && gap <= 381, "R2 new-frame gap", gap, 377);
    chk(wid[0] == 116, "R3 start low", wid[0], 116);
    chk(tfall[1] - tfall[0] == 141, "R3 start total", tfall[1] - tfall[0], 141);
    chk(wid[1] == 47, "R4 zero low", wid[1], 47);
    chk(wid[2] == 19, "R4 one low", wid[2], 19);
    chk(tfall[2] - tfall[1] == 75, "R4 bit total", tfall[2] - tfall[1], 75);

    send(1, 8'h40, 8'h00, 1'b0, 1'b0);
    gap = tfall[0] - t_wr;
    chk(gap >= 525 && gap <= 531, "R2 next-frame gap", gap, 527);

    send(1, 8'h40, 8'h00, 1'b0, 1'b1);
    gap = tfall[0] - t_wr;
    chk(gap >= 225 && gap <= 231, "R2 retry gap", gap, 227);

    // R7 underrun: first byte not final, nothing follows
    clr_mon();
    wr_word(8'h40, 1'b1, 1'b0, 1'b0, 1'b0);
    wait_end();
    chk(f_und == 1, "R7 underrun", f_und, 1);
    chk(f_done == 0, "R7 no done", f_done, 0);

    // R8 arbitration: line low during address bit 1 (a 1 bit of 0x4F)
    arb_fall = 3;
    send(1, 8'h4F, 8'h00, 1'b0, 1'b0);
    chk(f_arb == 1, "R8 arb lost", f_arb, 1);
    step(300);
    chk(fall_n == 3, "R8 released", fall_n, 3);
    chk(f_anom == 0, "R8 not anomaly", f_anom, 0);

    // R9 anomaly: line low during data bit 5 (a 1 bit of 0x0F)
    arb_fall = 7;
    send(1, 8'h0F, 8'h00, 1'b0, 1'b0);
    chk(f_anom == 1, "R9 anomaly", f_anom, 1);
    chk(f_arb == 0, "R9 not arb", f_arb, 0);
    chk(wid[7] == 113, "R9 error low", wid[7], 113);
    arb_fall = 0;

    // R1 a word without the start flag is dropped while idle
    clr_mon();
    wr_word(8'h33, 1'b0, 1'b1, 1'b0, 1'b0);
    step(3);
    chk(tx_empty == 1, "R1 dropped word", tx_empty, 1);
    step(700);
    chk(fall_n == 0, "R1 no drive", fall_n, 0);

    // R11 disable during the start bit
    clr_mon();
    wr_word(8'h40, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 2000; i++) begin
      if (drive_low) break;
      step(1);
    end
    en = 0;
    step(1);
    chk(drive_low == 0, "R11 released", drive_low, 0);
    chk(tx_empty == 1, "R11 holding cleared", tx_empty, 1);
    en = 1;
    step(800);
    chk(fall_n == 1, "R11 stays idle", fall_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule